// File: doc/BRIEF.md
# Soft-Reset Register Bank with Write Mask

This block holds a small set of software-visible control words whose bits drive individual reset lines to on-chip peripherals. A stored 1 holds the matching peripheral in reset. A stored 0 lets it run. Software reaches the words over a simple register bus: a byte address, a write strobe, 32-bit write data and combinational read data. The reset lines leave the block as one flat vector.

The `MASKED` parameter chooses between two build variants. In the masked variant each word carries 16 lines in its low half. The high half of every write is a per-bit enable for the low half, so one write sets or clears one line without touching the others, and software needs no read-modify-write and no lock. In the plain variant each word carries 32 lines, and a write replaces the whole word.

Top module: `srst_bank`

## Requirements
- R1: After the power-on reset input (`rstN` low) every stored bit is 0, so every reset line is released and every in-range read returns 0.
- R2: Reset line N is bit (N mod L) of word N/L, where L is 16 in masked mode and 32 in plain mode. Word w sits at byte address 4·w, and the vector has `NUM_REGS`·L lines.
- R3: In masked mode, a write with bit k and bit k+16 both set drives line k of the addressed word to 1.
- R4: In masked mode, a write with bit k+16 set and bit k clear drives line k of the addressed word to 0.
- R5: In masked mode, a low bit whose enable bit (16 positions higher) is 0 in the write keeps its stored value.
- R6: In plain mode, a write replaces all 32 bits of the addressed word with the write data.
- R7: A read of an in-range word returns its stored bits in the low L bits. In masked mode bits 31:16 read as 0, because the enables are not stored.
- R8: A write whose word index (address bits above the lowest two) is `NUM_REGS` or more changes no reset line.
- R9: A read whose word index is `NUM_REGS` or more returns 0.
- R10: The reset lines are registered. They still show the old value while the write is presented and take the new value after the clock edge that accepts the write.
- R11: A write changes no line of any word other than the addressed one.
- R12: When no write is presented, the reset lines hold their value across a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| busAddr | input | ADDR_W | Byte address; bits 1:0 ignored |
| busWrEn | input | 1 | Write strobe, accepted on the rising clock edge |
| busWrData | input | 32 | Write data (high half is the enable mask in masked mode) |
| busRdData | output | 32 | Combinational read data for `busAddr` |
| resetLines | output | NUM_REGS·L | Reset lines; 1 holds the peripheral in reset |

## Verification
The checker tests these properties on every cycle: enable-masked bits are preserved, enabled bits follow the write data, untargeted words stay untouched, the lines stay stable with no write or with an out-of-range write, and read data matches the stored lines with zero high bits and zero out-of-range reads. The bench sweeps every line of a three-word masked bank, setting each line one at a time and then clearing each one. A plain two-word bank shares the same bus, so one address is in range for one variant and out of range for the other. Only these scenarios show that the line numbering matches the intended physical order and that the reset state comes out as expected. They also show that the old value is visible while a write is presented and the new value appears only after the edge that accepts it.

// File: rtl/srst_pkg.sv
package srst_pkg;
  localparam int BusW  = 32;
  localparam int HalfW = 16;

  // Strobes from address decode to the register datapath.
  typedef struct packed {
    logic wrStrobe;  // in-range write this cycle
    logic rdHit;     // address falls on an implemented word
  } srstStrobeT;
endpackage

// File: rtl/srst_ctrl.sv
module srst_ctrl
  import srst_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 8,
  parameter int IDX_W    = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output srstStrobeT        strobe,
  output logic [IDX_W-1:0]  regIdx
);
  localparam int WordW = ADDR_W - 2;

  logic [WordW-1:0] wordAddr;
  logic             inRange;

  assign wordAddr = busAddr[ADDR_W-1:2];
  assign inRange  = (int'(wordAddr) < NUM_REGS);
  assign regIdx   = IDX_W'(wordAddr);

  always_comb begin
    strobe.rdHit    = inRange;
    strobe.wrStrobe = inRange && busWrEn;
  end
endmodule

// File: rtl/srst_datapath.sv
module srst_datapath
  import srst_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int LPR      = 16,
  parameter int MASKED   = 1,
  parameter int IDX_W    = 2,
  localparam int NumLines = NUM_REGS * LPR
) (
  input  logic                clk,
  input  logic                rstN,
  input  srstStrobeT          strobe,
  input  logic [IDX_W-1:0]    regIdx,
  input  logic [BusW-1:0]     wrData,
  output logic [BusW-1:0]     rdData,
  output logic [NumLines-1:0] lines
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
    logic [LPR-1:0] wordQ;
    logic [LPR-1:0] wordNext;
    logic           selWord;

    assign selWord = strobe.wrStrobe && (regIdx == IDX_W'(r));

    if (MASKED != 0) begin : g_masked
      logic [LPR-1:0] enBits;
      assign enBits   = wrData[HalfW +: LPR];
      assign wordNext = (wordQ & ~enBits) | (wrData[LPR-1:0] & enBits);
    end else begin : g_plain
      assign wordNext = wrData[LPR-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        wordQ <= '0;
      else if (selWord) wordQ <= wordNext;
    end

    assign lines[r*LPR +: LPR] = wordQ;
  end

  logic [LPR-1:0] rdSlice;
  assign rdSlice = LPR'(lines >> (int'(regIdx) * LPR));
  assign rdData  = strobe.rdHit ? BusW'(rdSlice) : '0;
endmodule

// File: rtl/srst_bank.sv
module srst_bank
  import srst_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int MASKED   = 1,
  parameter int ADDR_W   = 8,
  localparam int Lpr     = (MASKED != 0) ? HalfW : BusW,
  localparam int NumLines = NUM_REGS * Lpr,
  localparam int IdxW    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [BusW-1:0]     busWrData,
  output logic [BusW-1:0]     busRdData,
  output logic [NumLines-1:0] resetLines
);
  srstStrobeT      strobe;
  logic [IdxW-1:0] regIdx;

  srst_ctrl #(
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IdxW)
  ) u_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strobe (strobe),
    .regIdx (regIdx)
  );

  srst_datapath #(
    .NUM_REGS(NUM_REGS),
    .LPR     (Lpr),
    .MASKED  (MASKED),
    .IDX_W   (IdxW)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .regIdx(regIdx),
    .wrData(busWrData),
    .rdData(busRdData),
    .lines (resetLines)
  );
endmodule

// File: rtl/srst_bank_chk.sv
module srst_bank_chk #(
  parameter int NUM_REGS = 4,
  parameter int MASKED   = 1,
  parameter int ADDR_W   = 8,
  localparam int Lpr      = (MASKED != 0) ? 16 : 32,
  localparam int NumLines = NUM_REGS * Lpr,
  localparam int WordW    = ADDR_W - 2
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWrEn,
  input logic [31:0]         busWrData,
  input logic [31:0]         busRdData,
  input logic [NumLines-1:0] resetLines
);
  logic [WordW-1:0]    wordAddr;
  logic                inRange;
  logic                prevWr;
  logic [WordW-1:0]    prevIdx;
  logic [31:0]         prevData;
  logic [NumLines-1:0] prevLines;
  logic [NumLines-1:0] tgtMask;
  logic [Lpr-1:0]      curSlice;
  logic [Lpr-1:0]      oldSlice;
  logic [Lpr-1:0]      enMask;
  logic [Lpr-1:0]      rdExpect;

  assign wordAddr = busAddr[ADDR_W-1:2];
  assign inRange  = (int'(wordAddr) < NUM_REGS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWr    <= 1'b0;
      prevIdx   <= '0;
      prevData  <= '0;
      prevLines <= '0;
    end else begin
      prevWr    <= busWrEn && inRange;
      prevIdx   <= wordAddr;
      prevData  <= busWrData;
      prevLines <= resetLines;
    end
  end

  assign tgtMask  = NumLines'({Lpr{1'b1}}) << (int'(prevIdx) * Lpr);
  assign curSlice = Lpr'(resetLines >> (int'(prevIdx) * Lpr));
  assign oldSlice = Lpr'(prevLines >> (int'(prevIdx) * Lpr));
  assign enMask   = (MASKED != 0) ? Lpr'(prevData >> 16) : '1;
  assign rdExpect = Lpr'(resetLines >> (int'(wordAddr) * Lpr));

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> resetLines == '0);

  assert_written_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    prevWr |-> (curSlice & enMask) == (Lpr'(prevData) & enMask));  // R4, R6 too

  assert_kept_bits_R5: assert property (@(posedge clk) disable iff (!rstN)
    prevWr |-> ((curSlice ^ oldSlice) & ~enMask) == '0);

  assert_other_words_R11: assert property (@(posedge clk) disable iff (!rstN)
    prevWr |-> ((resetLines ^ prevLines) & ~tgtMask) == '0);

  assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(resetLines));

  assert_oob_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !inRange) |=> $stable(resetLines));

  assert_oob_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inRange |-> busRdData == '0);

  assert_readback_R7: assert property (@(posedge clk) disable iff (!rstN)
    inRange |-> busRdData[Lpr-1:0] == rdExpect);

  if (MASKED != 0) begin : g_upper
    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
      busRdData[31:16] == 16'h0);
  end
endmodule

bind srst_bank srst_bank_chk #(
  .NUM_REGS(NUM_REGS),
  .MASKED  (MASKED),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .resetLines(resetLines)
);

// File: tb/srst_bank_tb.sv
module srst_bank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] rdM, rdP;
  logic [47:0] linesM;
  logic [63:0] linesP;

  logic [15:0] mM [3];
  logic [31:0] mP [2];
  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  srst_bank #(.NUM_REGS(3), .MASKED(1), .ADDR_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(rdM), .resetLines(linesM));

  srst_bank #(.NUM_REGS(2), .MASKED(0), .ADDR_W(8)) u_dutPlain (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(rdP), .resetLines(linesP));

  function automatic logic [47:0] flatM();
    logic [47:0] v;
    for (int i = 0; i < 3; i++) v[i*16 +: 16] = mM[i];
    return v;
  endfunction

  function automatic logic [63:0] flatP();
    return {mP[1], mP[0]};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [7:0] addr, logic [31:0] data, string tagM, string tagP);
    int idx;
    idx = int'(addr >> 2);
    @(negedge clk);
    busAddr = addr; busWrEn = 1'b1; busWrData = data;
    #1;
    check("R10 masked lines before edge", 64'(linesM), 64'(flatM()));
    check("R10 plain lines before edge", linesP, flatP());
    @(posedge clk);
    if (idx < 3) mM[idx] = (mM[idx] & ~data[31:16]) | (data[15:0] & data[31:16]);
    if (idx < 2) mP[idx] = data;
    @(negedge clk);
    busWrEn = 1'b0;
    #1;
    check(tagM, 64'(linesM), 64'(flatM()));
    check(tagP, linesP, flatP());
  endtask

  task automatic doRead(logic [7:0] addr);
    int idx;
    logic [47:0] keepM;
    logic [63:0] keepP;
    idx = int'(addr >> 2);
    @(negedge clk);
    busAddr = addr; busWrEn = 1'b0;
    keepM = linesM; keepP = linesP;
    #1;
    check(idx < 3 ? "R7 masked readback, high half zero" : "R9 masked out-of-range read",
          64'(rdM), idx < 3 ? 64'({16'h0, mM[idx]}) : 64'h0);
    check(idx < 2 ? "R7 plain readback" : "R9 plain out-of-range read",
          64'(rdP), idx < 2 ? 64'(mP[idx]) : 64'h0);
    @(negedge clk);
    check("R12 masked lines hold without write", 64'(linesM), 64'(keepM));
    check("R12 plain lines hold without write", linesP, keepP);
  endtask

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < 3; i++) mM[i] = '0;
    for (int i = 0; i < 2; i++) mP[i] = '0;
    // Hold a few writes on the bus during reset: they must not land.
    busAddr = 8'h0; busWrEn = 1'b1; busWrData = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R1 masked lines in reset", 64'(linesM), 64'h0);
    check("R1 plain lines in reset", linesP, 64'h0);
    busWrEn = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1 masked lines after reset", 64'(linesM), 64'h0);
    check("R1 plain lines after reset", linesP, 64'h0);

    // Reset-state readback and out-of-range reads.
    for (int a = 0; a < 8; a++) doRead(8'(a * 4));

    // Set each masked line alone (R2, R3).
    for (int n = 0; n < 48; n++) begin
      doWrite(8'((n / 16) * 4), (32'h1 << (n % 16)) | (32'h1 << (n % 16 + 16)),
              "R3 masked set line", "R6 plain wholesale write");
      check("R2 line position", 64'(linesM[n]), 64'h1);
    end
    check("R2 all 48 lines set", 64'(linesM), 64'hFFFF_FFFF_FFFF);
    for (int a = 0; a < 4; a++) doRead(8'(a * 4));

    // Clear each masked line alone (R4).
    for (int n = 47; n >= 0; n--) begin
      doWrite(8'((n / 16) * 4), 32'h1 << (n % 16 + 16),
              "R4 masked clear line", "R6 plain wholesale write");
      check("R4 line cleared", 64'(linesM[n]), 64'h0);
    end

    // Enable bits all zero leave the word unchanged (R5).
    doWrite(8'h4, 32'h00FF_00FF, "R3 masked partial set", "R6 plain wholesale write");
    doWrite(8'h4, 32'h0000_FFFF, "R5 masked no-enable write", "R6 plain wholesale write");
    check("R5 word 1 kept", 64'(linesM[31:16]), 64'h00FF);

    // Out-of-range writes for both variants (R8).
    doWrite(8'hC, 32'hFFFF_FFFF, "R8 masked out-of-range write", "R8 plain out-of-range write");
    doWrite(8'hFC, 32'hFFFF_FFFF, "R8 masked far write", "R8 plain far write");
    doWrite(8'h8, 32'hA5A5_5A5A, "R3 masked word 2", "R8 plain word 2 out of range");

    // Pseudo-random mixed traffic (R5, R6, R11).
    lfsr = 32'h1234_5678;
    for (int i = 0; i < 120; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      doWrite({3'b000, lfsr[4:2], lfsr[6:5]}, {lfsr[15:0], lfsr[31:16]} ^ lfsr,
              "R5 R11 masked random write", "R6 R11 plain random write");
      if (i % 8 == 0) doRead({3'b000, lfsr[9:7], 2'b00});
    end
    for (int a = 0; a < 8; a++) doRead(8'(a * 4 + (a % 4)));

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule